// File: doc/BRIEF.md
# Pixel Readout Row and Frame Timing Generator

This block sequences the readout of a pixel array at one pixel per clock. From a set of geometry inputs (column and row window size, column and row skip, horizontal and vertical blanking, shutter width, row and column binning codes) it derives the output window, the row length in clocks and the frame length in rows. It then scans a column counter and a row counter and produces line-valid, frame-valid, row-start and frame-start strobes for the downstream pixel path.

Blanking is never taken at face value. The horizontal blank is raised to a minimum set by the binning codes, and the whole half-row is raised to a floor set by row binning. The vertical blank is raised to a minimum that grows with the shutter width once the exposure runs longer than the active window. Geometry is captured into shadow registers only when a frame's last active row ends. A frame that has started therefore keeps its window, and the blanking that follows uses the new settings.

Top module: `sensor_readout_timing`

## Requirements
- R1: While rst_ni is low, every strobe output is 0 and row_cnt_o and col_cnt_o are 0; asserting rst_ni low mid-frame clears them at once.
- R2: Active width W = 2 × ceil((col_size_i + 1) / (2 × (col_skip_i + 1))); line_valid_o is high for exactly W clocks starting at column 0 of each active row.
- R3: Active height H = 2 × ceil((row_size_i + 1) / (2 × (row_skip_i + 1))); exactly H rows per frame carry line_valid_o.
- R4: Row length in clocks is 2 × max(W/2 + max(hblank_i + 1, HBmin), 140 + 346 × (rb + 1)), where rb is the normalised row-bin code; col_cnt_o counts 0 to row length − 1 and wraps.
- R5: HBmin is 450 for row-bin 0, 796 for row-bin 1 and 1488 for row-bin 3, reduced by 20 for column-bin 1 and by 30 for column-bin 3; a bin code of 2 on either input is handled as code 0 in both HBmin and the row floor.
- R6: Frame length in rows is H + max(vblank_i + 1, max(8, SW − H) + 1), with SW = max(1, shut_hi_i × 65536 + shut_lo_i).
- R7: frame_valid_o rises with the first active pixel of row 0 and falls after pixel W − 1 of row H − 1, so it is high for (H − 1) × row length + W clocks per frame.
- R8: frame_start_o is high for one clock at row 0, column 0; row_start_o is high at column 0 of every row, blanking rows included.
- R9: Geometry inputs changed during a frame's active rows do not alter that frame's active rows; they govern the blanking after its last active row and every following frame.
- R10: row_cnt_o is 0 at frame start and reaches frame length − 1 before wrapping; col_cnt_o is 0 whenever row_start_o is high.
- R11: After rst_ni rises, the first frame starts at the second rising clock edge: frame_start_o, line_valid_o and frame_valid_o are high after that edge and low after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_size_i | input | COL_W | Column window size minus one |
| col_skip_i | input | SKIP_W | Column skip factor |
| row_size_i | input | ROW_W | Row window size minus one |
| row_skip_i | input | SKIP_W | Row skip factor |
| hblank_i | input | HB_W | Programmed horizontal blank minus one |
| vblank_i | input | VB_W | Programmed vertical blank minus one |
| shut_hi_i | input | SWU_W | Shutter width, upper word (weight 65536) |
| shut_lo_i | input | 16 | Shutter width, lower word |
| row_bin_i | input | 2 | Row binning code (0, 1, 3) |
| col_bin_i | input | 2 | Column binning code (0, 1, 3) |
| line_valid_o | output | 1 | Active pixel in an active row |
| frame_valid_o | output | 1 | Inside the active window of a frame |
| row_start_o | output | 1 | Column 0 of any row |
| frame_start_o | output | 1 | Row 0, column 0 |
| row_cnt_o | output | FR_W | Current row in frame |
| col_cnt_o | output | RLEN_W | Current column in row |

## Verification
All strobes are decoded without a register from the counter state, so each is valid right after the edge that moves the counters and is sampled on the following falling edge. A geometry change needs one edge to reach the geometry register and then waits for the end of the last active row. The bench applies each setting at a frame start, checks that row 1 of that same frame keeps the old width and length, and measures the next full frame. Start-up is checked after the first and after the second rising edge following reset release.

// File: rtl/srt_pkg.sv
`timescale 1ns/1ps
package srt_pkg;

  localparam int SHUT_LO_W = 16;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // half-row accumulator + 1 for the doubled row length
  function automatic int row_len_w(input int col_w, input int hb_w);
    return imax(col_w, imax(hb_w + 1, 11)) + 2;
  endfunction

  function automatic int frame_rows_w(input int row_w, input int vb_w, input int swu_w);
    return imax(row_w + 1, imax(vb_w + 1, SHUT_LO_W + swu_w + 1)) + 1;
  endfunction

  function automatic logic [1:0] bin_norm(input logic [1:0] code);
    return (code == 2'd2) ? 2'd0 : code;
  endfunction

  function automatic logic [10:0] hbmin_lut(input logic [1:0] rb, input logic [1:0] cb);
    logic [10:0] base;
    logic [10:0] cut;
    case (bin_norm(rb))
      2'd1:    base = 11'd796;
      2'd3:    base = 11'd1488;
      default: base = 11'd450;
    endcase
    case (bin_norm(cb))
      2'd1:    cut = 11'd20;
      2'd3:    cut = 11'd30;
      default: cut = 11'd0;
    endcase
    return base - cut;
  endfunction

  // 41 + 99 + 346 * (rb + 1)
  function automatic logic [10:0] row_floor(input logic [1:0] rb);
    case (bin_norm(rb))
      2'd1:    return 11'd832;
      2'd3:    return 11'd1524;
      default: return 11'd486;
    endcase
  endfunction

endpackage

// File: rtl/srt_even_ceil.sv
`timescale 1ns/1ps
module srt_even_ceil #(
  parameter int N_W = 12,
  parameter int S_W = 3,
  parameter int O_W = N_W + 1
) (
  input  logic [N_W-1:0] size_i,
  input  logic [S_W-1:0] skip_i,
  output logic [O_W-1:0] dim_o
);
  localparam int A_W = N_W + S_W + 3;

  logic [A_W-1:0] num, den, quo;

  always_comb begin
    num = A_W'(size_i) + A_W'(1);
    den = (A_W'(skip_i) + A_W'(1)) << 1;
    quo = (num + den - A_W'(1)) / den;
    if (quo == '0) quo = A_W'(1);
    dim_o = O_W'(quo << 1);
  end
endmodule

// File: rtl/srt_geom_calc.sv
`timescale 1ns/1ps
module srt_geom_calc #(
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12,
  parameter int SKIP_W = 3,
  parameter int HB_W   = 12,
  parameter int VB_W   = 12,
  parameter int SWU_W  = 4,
  parameter int W_W    = COL_W + 1,
  parameter int H_W    = ROW_W + 1,
  parameter int RLEN_W = srt_pkg::row_len_w(COL_W, HB_W),
  parameter int FR_W   = srt_pkg::frame_rows_w(ROW_W, VB_W, SWU_W)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [COL_W-1:0]              col_size_i,
  input  logic [SKIP_W-1:0]             col_skip_i,
  input  logic [ROW_W-1:0]              row_size_i,
  input  logic [SKIP_W-1:0]             row_skip_i,
  input  logic [HB_W-1:0]               hblank_i,
  input  logic [VB_W-1:0]               vblank_i,
  input  logic [SWU_W-1:0]              shut_hi_i,
  input  logic [srt_pkg::SHUT_LO_W-1:0] shut_lo_i,
  input  logic [1:0]                    row_bin_i,
  input  logic [1:0]                    col_bin_i,
  output logic [W_W-1:0]                w_o,
  output logic [H_W-1:0]                h_o,
  output logic [RLEN_W-1:0]             row_len_o,
  output logic [FR_W-1:0]               frame_rows_o
);
  localparam int HBU_W  = srt_pkg::imax(HB_W + 1, 11);
  localparam int HALF_W = RLEN_W - 1;
  localparam int SW_W   = srt_pkg::SHUT_LO_W + SWU_W;
  localparam int CMP_W  = srt_pkg::imax(SW_W, H_W) + 2;

  logic [W_W-1:0]    w_c;
  logic [H_W-1:0]    h_c;
  logic [HBU_W-1:0]  hb_eff, hb_min, hb_use;
  logic [HALF_W-1:0] half_act, half_flr, half_use;
  logic [SW_W-1:0]   sw_raw, sw;
  logic [FR_W-1:0]   vb_eff, vb_min;
  logic              vld_q;

  srt_even_ceil #(.N_W(COL_W), .S_W(SKIP_W), .O_W(W_W)) u_width (
    .size_i(col_size_i), .skip_i(col_skip_i), .dim_o(w_c)
  );

  srt_even_ceil #(.N_W(ROW_W), .S_W(SKIP_W), .O_W(H_W)) u_height (
    .size_i(row_size_i), .skip_i(row_skip_i), .dim_o(h_c)
  );

  always_comb begin
    hb_eff   = HBU_W'(hblank_i) + HBU_W'(1);
    hb_min   = HBU_W'(srt_pkg::hbmin_lut(row_bin_i, col_bin_i));
    hb_use   = (hb_eff > hb_min) ? hb_eff : hb_min;
    half_act = HALF_W'(w_c >> 1) + HALF_W'(hb_use);
    half_flr = HALF_W'(srt_pkg::row_floor(row_bin_i));
    half_use = (half_act > half_flr) ? half_act : half_flr;

    sw_raw = {shut_hi_i, shut_lo_i};
    sw     = (sw_raw == '0) ? SW_W'(1) : sw_raw;
    // max(8, sw - h) + 1
    if (CMP_W'(sw) > CMP_W'(h_c) + CMP_W'(8))
      vb_min = FR_W'(CMP_W'(sw) - CMP_W'(h_c) + CMP_W'(1));
    else
      vb_min = FR_W'(9);
    vb_eff = FR_W'(vblank_i) + FR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q        <= 1'b0;
      w_o          <= '0;
      h_o          <= '0;
      row_len_o    <= '0;
      frame_rows_o <= '0;
    end else begin
      vld_q        <= 1'b1;
      w_o          <= w_c;
      h_o          <= h_c;
      row_len_o    <= {half_use, 1'b0};
      frame_rows_o <= FR_W'(h_c) + ((vb_eff > vb_min) ? vb_eff : vb_min);
    end
  end

  p_dims_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (w_o[0] == 1'b0 && h_o[0] == 1'b0 && w_o != '0 && h_o != '0));

  p_row_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (row_len_o >= RLEN_W'(972) && row_len_o > RLEN_W'(w_o)));

  p_vblank_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (frame_rows_o >= FR_W'(h_o) + FR_W'(9)));
endmodule

// File: rtl/srt_scan_ctr.sv
`timescale 1ns/1ps
module srt_scan_ctr #(
  parameter int W_W    = 13,
  parameter int H_W    = 13,
  parameter int RLEN_W = 15,
  parameter int FR_W   = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W_W-1:0]    w_i,
  input  logic [H_W-1:0]    h_i,
  input  logic [RLEN_W-1:0] row_len_i,
  input  logic [FR_W-1:0]   frame_rows_i,
  output logic              primed_o,
  output logic              in_blank_o,
  output logic [FR_W-1:0]   row_o,
  output logic [RLEN_W-1:0] col_o,
  output logic [W_W-1:0]    sh_w_o,
  output logic [H_W-1:0]    sh_h_o
);
  logic              init_q, primed_q, in_blank_q;
  logic [FR_W-1:0]   row_q;
  logic [RLEN_W-1:0] col_q;
  logic [W_W-1:0]    sh_w_q;
  logic [H_W-1:0]    sh_h_q;
  logic [RLEN_W-1:0] sh_rlen_q;
  logic [FR_W-1:0]   sh_frows_q;
  logic              col_last, row_last, blank_entry, load_shadow;

  always_comb begin
    col_last    = (col_q >= sh_rlen_q - RLEN_W'(1));
    row_last    = (row_q >= sh_frows_q - FR_W'(1));
    blank_entry = !in_blank_q && (row_q == FR_W'(sh_h_q) - FR_W'(1));
    load_shadow = primed_q ? (col_last && blank_entry) : init_q;
  end

  // geometry only moves at the end of the last active row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_w_q     <= '0;
      sh_h_q     <= '0;
      sh_rlen_q  <= '0;
      sh_frows_q <= '0;
    end else if (load_shadow) begin
      sh_w_q     <= w_i;
      sh_h_q     <= h_i;
      sh_rlen_q  <= row_len_i;
      sh_frows_q <= frame_rows_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q     <= 1'b0;
      primed_q   <= 1'b0;
      in_blank_q <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
    end else begin
      init_q <= 1'b1;
      if (!primed_q) begin
        primed_q <= init_q;
      end else if (col_last) begin
        col_q <= '0;
        if (row_last) begin
          row_q      <= '0;
          in_blank_q <= 1'b0;
        end else if (blank_entry) begin
          // blank rows are counted against the newly loaded height
          row_q      <= FR_W'(h_i);
          in_blank_q <= 1'b1;
        end else begin
          row_q <= row_q + FR_W'(1);
        end
      end else begin
        col_q <= col_q + RLEN_W'(1);
      end
    end
  end

  assign primed_o   = primed_q;
  assign in_blank_o = in_blank_q;
  assign row_o      = row_q;
  assign col_o      = col_q;
  assign sh_w_o     = sh_w_q;
  assign sh_h_o     = sh_h_q;

  p_col_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && !col_last) |=> (col_q == $past(col_q) + RLEN_W'(1)));

  p_col_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && col_last) |=> (col_q == '0));

  p_row_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (row_q < sh_frows_q));

  p_blank_rows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_blank_q |-> (row_q >= FR_W'(sh_h_q)));

  p_shadow_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && !in_blank_q && (row_q + FR_W'(1) < FR_W'(sh_h_q)))
      |=> ($stable(sh_w_q) && $stable(sh_h_q) && $stable(sh_rlen_q) && $stable(sh_frows_q)));
endmodule

// File: rtl/srt_strobes.sv
`timescale 1ns/1ps
module srt_strobes #(
  parameter int W_W    = 13,
  parameter int H_W    = 13,
  parameter int RLEN_W = 15,
  parameter int FR_W   = 22
) (
  input  logic              primed_i,
  input  logic              in_blank_i,
  input  logic [FR_W-1:0]   row_i,
  input  logic [RLEN_W-1:0] col_i,
  input  logic [W_W-1:0]    w_i,
  input  logic [H_W-1:0]    h_i,
  output logic              line_valid_o,
  output logic              frame_valid_o,
  output logic              row_start_o,
  output logic              frame_start_o
);
  logic in_width, last_act_row;

  always_comb begin
    in_width      = col_i < RLEN_W'(w_i);
    last_act_row  = row_i == FR_W'(h_i) - FR_W'(1);
    line_valid_o  = primed_i && !in_blank_i && in_width;
    frame_valid_o = primed_i && !in_blank_i && (!last_act_row || in_width);
    row_start_o   = primed_i && (col_i == '0);
    frame_start_o = primed_i && (col_i == '0) && (row_i == '0);
  end
endmodule

// File: rtl/sensor_readout_timing.sv
`timescale 1ns/1ps
module sensor_readout_timing #(
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12,
  parameter int SKIP_W = 3,
  parameter int HB_W   = 12,
  parameter int VB_W   = 12,
  parameter int SWU_W  = 4,
  localparam int W_W    = COL_W + 1,
  localparam int H_W    = ROW_W + 1,
  localparam int RLEN_W = srt_pkg::row_len_w(COL_W, HB_W),
  localparam int FR_W   = srt_pkg::frame_rows_w(ROW_W, VB_W, SWU_W)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [COL_W-1:0]              col_size_i,
  input  logic [SKIP_W-1:0]             col_skip_i,
  input  logic [ROW_W-1:0]              row_size_i,
  input  logic [SKIP_W-1:0]             row_skip_i,
  input  logic [HB_W-1:0]               hblank_i,
  input  logic [VB_W-1:0]               vblank_i,
  input  logic [SWU_W-1:0]              shut_hi_i,
  input  logic [srt_pkg::SHUT_LO_W-1:0] shut_lo_i,
  input  logic [1:0]                    row_bin_i,
  input  logic [1:0]                    col_bin_i,
  output logic                          line_valid_o,
  output logic                          frame_valid_o,
  output logic                          row_start_o,
  output logic                          frame_start_o,
  output logic [FR_W-1:0]               row_cnt_o,
  output logic [RLEN_W-1:0]             col_cnt_o
);
  logic [W_W-1:0]    geo_w, sh_w;
  logic [H_W-1:0]    geo_h, sh_h;
  logic [RLEN_W-1:0] geo_rlen;
  logic [FR_W-1:0]   geo_frows;
  logic              primed, in_blank;

  srt_geom_calc #(
    .COL_W(COL_W), .ROW_W(ROW_W), .SKIP_W(SKIP_W), .HB_W(HB_W), .VB_W(VB_W),
    .SWU_W(SWU_W), .W_W(W_W), .H_W(H_W), .RLEN_W(RLEN_W), .FR_W(FR_W)
  ) u_geom (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .col_size_i(col_size_i), .col_skip_i(col_skip_i),
    .row_size_i(row_size_i), .row_skip_i(row_skip_i),
    .hblank_i(hblank_i), .vblank_i(vblank_i),
    .shut_hi_i(shut_hi_i), .shut_lo_i(shut_lo_i),
    .row_bin_i(row_bin_i), .col_bin_i(col_bin_i),
    .w_o(geo_w), .h_o(geo_h), .row_len_o(geo_rlen), .frame_rows_o(geo_frows)
  );

  srt_scan_ctr #(.W_W(W_W), .H_W(H_W), .RLEN_W(RLEN_W), .FR_W(FR_W)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .w_i(geo_w), .h_i(geo_h), .row_len_i(geo_rlen), .frame_rows_i(geo_frows),
    .primed_o(primed), .in_blank_o(in_blank),
    .row_o(row_cnt_o), .col_o(col_cnt_o),
    .sh_w_o(sh_w), .sh_h_o(sh_h)
  );

  srt_strobes #(.W_W(W_W), .H_W(H_W), .RLEN_W(RLEN_W), .FR_W(FR_W)) u_strb (
    .primed_i(primed), .in_blank_i(in_blank),
    .row_i(row_cnt_o), .col_i(col_cnt_o),
    .w_i(sh_w), .h_i(sh_h),
    .line_valid_o(line_valid_o), .frame_valid_o(frame_valid_o),
    .row_start_o(row_start_o), .frame_start_o(frame_start_o)
  );

  p_lv_in_fv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> frame_valid_o);

  p_fs_with_rs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (row_start_o && line_valid_o && row_cnt_o == '0));

  p_fs_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  p_lv_rise_col0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_valid_o) |-> (col_cnt_o == '0));

  p_rs_col0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_start_o |-> (col_cnt_o == '0));
endmodule

// File: tb/sensor_readout_timing_test.sv
`timescale 1ns/1ps
module sensor_readout_timing_test;
  localparam int COL_W  = 12;
  localparam int ROW_W  = 12;
  localparam int SKIP_W = 3;
  localparam int HB_W   = 12;
  localparam int VB_W   = 12;
  localparam int SWU_W  = 4;
  localparam int RLEN_W = srt_pkg::row_len_w(COL_W, HB_W);
  localparam int FR_W   = srt_pkg::frame_rows_w(ROW_W, VB_W, SWU_W);

  // col_size, col_skip, row_size, row_skip, hblank, vblank, shut_hi, shut_lo,
  // row_bin, col_bin | expected W, H, row length, frame rows
  localparam int NV = 5;
  localparam int NF = 14;
  localparam int VEC [NV][NF] = '{
    '{15, 0, 3, 0,   0, 0, 0,  1, 0, 0,  16, 4,  972, 13},  // floor wins
    '{20, 1, 9, 2, 499, 2, 0, 14, 0, 1,  12, 4, 1012, 15},  // programmed HB, SW-driven VB
    '{ 7, 0, 1, 0,   0, 9, 0,  1, 1, 3,   8, 2, 1664, 12},  // row-bin floor, programmed VB
    '{99, 0, 4, 0,   0, 0, 0,  0, 2, 2, 100, 6, 1000, 15},  // code 2 as 0, HBmin wins, ceil rounds up
    '{15, 0, 3, 0,   0, 0, 0, 20, 0, 0,  16, 4,  972, 21}   // long shutter stretches VB
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [COL_W-1:0]  col_size;
  logic [SKIP_W-1:0] col_skip, row_skip;
  logic [ROW_W-1:0]  row_size;
  logic [HB_W-1:0]   hblank;
  logic [VB_W-1:0]   vblank;
  logic [SWU_W-1:0]  shut_hi;
  logic [15:0]       shut_lo;
  logic [1:0]        row_bin, col_bin;
  logic line_valid, frame_valid, row_start, frame_start;
  logic [FR_W-1:0]   row_cnt;
  logic [RLEN_W-1:0] col_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sensor_readout_timing #(
    .COL_W(COL_W), .ROW_W(ROW_W), .SKIP_W(SKIP_W), .HB_W(HB_W), .VB_W(VB_W), .SWU_W(SWU_W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .col_size_i(col_size), .col_skip_i(col_skip),
    .row_size_i(row_size), .row_skip_i(row_skip),
    .hblank_i(hblank), .vblank_i(vblank),
    .shut_hi_i(shut_hi), .shut_lo_i(shut_lo),
    .row_bin_i(row_bin), .col_bin_i(col_bin),
    .line_valid_o(line_valid), .frame_valid_o(frame_valid),
    .row_start_o(row_start), .frame_start_o(frame_start),
    .row_cnt_o(row_cnt), .col_cnt_o(col_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int v);
    col_size = COL_W'(VEC[v][0]);
    col_skip = SKIP_W'(VEC[v][1]);
    row_size = ROW_W'(VEC[v][2]);
    row_skip = SKIP_W'(VEC[v][3]);
    hblank   = HB_W'(VEC[v][4]);
    vblank   = VB_W'(VEC[v][5]);
    shut_hi  = SWU_W'(VEC[v][6]);
    shut_lo  = 16'(VEC[v][7]);
    row_bin  = 2'(VEC[v][8]);
    col_bin  = 2'(VEC[v][9]);
  endtask

  task automatic wait_fs();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!frame_start && g < 60000);
    chk(frame_start, "R8 next frame_start arrives", int'(frame_start), 1);
  endtask

  // called on the falling edge where frame_start is seen
  task automatic measure_frame(input int v);
    int cyc = 0, rs = 0, lv = 0, fv = 0, lv_rows = 0, row_lv = 0;
    int rlen = 0, lv0 = 0, bad_col = 0, max_row = 0, fs = 0;
    int ew = VEC[v][10], eh = VEC[v][11], erl = VEC[v][12], efr = VEC[v][13];
    chk(row_cnt == '0, "R10 row_cnt at frame start", int'(row_cnt), 0);
    forever begin
      if (row_start) begin
        if (col_cnt != '0) bad_col++;
        if (rs == 1) begin
          rlen = cyc;
          lv0  = row_lv;
        end
        if (rs > 0 && row_lv > 0) lv_rows++;
        row_lv = 0;
        rs++;
      end
      if (frame_start) fs++;
      if (line_valid) begin
        lv++;
        row_lv++;
      end
      if (frame_valid) fv++;
      if (int'(row_cnt) > max_row) max_row = int'(row_cnt);
      @(negedge clk);
      cyc++;
      if (frame_start || cyc > 60000) break;
    end
    if (row_lv > 0) lv_rows++;
    chk(lv0 == ew, "R2 line_valid length in row 0", lv0, ew);
    chk(lv == ew * eh, "R2 line_valid clocks per frame", lv, ew * eh);
    chk(lv_rows == eh, "R3 active rows per frame", lv_rows, eh);
    chk(rlen == erl, "R4/R5 row length", rlen, erl);
    chk(cyc == erl * efr, "R4/R6 frame length in clocks", cyc, erl * efr);
    chk(rs == efr, "R6/R8 row_start pulses per frame", rs, efr);
    chk(fv == (eh - 1) * erl + ew, "R7 frame_valid clocks", fv, (eh - 1) * erl + ew);
    chk(fs == 1, "R8 frame_start pulses per frame", fs, 1);
    chk(max_row == efr - 1, "R10 highest row_cnt", max_row, efr - 1);
    chk(bad_col == 0, "R10 col_cnt zero at row_start", bad_col, 0);
  endtask

  // inputs were just changed at a frame start; row 1 must keep the old geometry
  task automatic check_old(input int v_old);
    int g = 0, c = 0, l = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!(row_start && row_cnt == FR_W'(1)) && g < 60000);
    do begin
      if (line_valid) l++;
      @(negedge clk);
      c++;
    end while (!row_start && c < 60000);
    chk(l == VEC[v_old][10], "R9 width kept in current frame", l, VEC[v_old][10]);
    chk(c == VEC[v_old][12], "R9 row length kept in current frame", c, VEC[v_old][12]);
    wait_fs();
  endtask

  initial begin
    apply(0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!line_valid && !frame_valid && !row_start && !frame_start,
        "R1 strobes low in reset", int'({line_valid, frame_valid, row_start, frame_start}), 0);
    chk(row_cnt == '0 && col_cnt == '0, "R1 counters zero in reset",
        int'(row_cnt) + int'(col_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!frame_start && !line_valid, "R11 idle after first edge",
        int'({frame_start, line_valid}), 0);
    @(negedge clk);
    chk(frame_start && line_valid && frame_valid, "R11 frame begins at second edge",
        int'({frame_start, line_valid, frame_valid}), 7);

    // vector table walk
    measure_frame(0);
    for (int v = 1; v < NV; v++) begin
      apply(v);
      check_old(v - 1);
      measure_frame(v);
    end

    // R1: asynchronous reset in the middle of a row
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!line_valid && !frame_valid && !row_start && !frame_start,
        "R1 strobes cleared by mid-frame reset",
        int'({line_valid, frame_valid, row_start, frame_start}), 0);
    chk(row_cnt == '0 && col_cnt == '0, "R1 counters cleared by mid-frame reset",
        int'(row_cnt) + int'(col_cnt), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R8: got %0d completed runs expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule